// File: doc/BRIEF.md
# Configuration Register Loader over I2C

This block is an I2C target that runs at standard-mode speed (100 kbit/s or slower). It holds a small bank of 8-bit configuration registers. A host loads the bank with a block write. The frame is the target address with the write bit, a command byte, a count byte and then the data bytes. The target acknowledges the command and count bytes but does not use their values. Data always lands at register 0 first and then in ascending order until the host ends the transfer.

A block read returns the register count first and then every register, lowest index first, most significant bit first. Any start or stop condition resets the transfer position, so every transaction begins again at register 0.

The block samples SCL and SDA with its own system clock through synchronisers. It detects start and stop conditions from edges on the synchronised lines. Its only drive onto the bus is an open-drain pull-down enable for SDA. The register contents are presented as one flat vector to the logic they configure.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset the registers are, from index 0 to 5: 00h, 1Fh, FFh, FFh, EBh, FFh. SDA is released.
- R2: The target acknowledges only the address bytes D2h (write) and D3h (read). For any other address it gives no acknowledge, and SDA stays released until the next start.
- R3: In a write, the target acknowledges the command byte and the count byte, and their values leave every register unchanged.
- R4: In a write, the data bytes are stored in order into registers 0, 1, 2 and so on, each with an acknowledge. A stop after any complete byte leaves all later registers unchanged.
- R5: Data bytes past the last register are acknowledged and change no register.
- R6: A read returns a count byte equal to 6 (the number of registers), then registers 0 to 5. Every byte is sent most significant bit first.
- R7: When the host answers a read byte with a not-acknowledge, the target releases SDA and sends nothing more until the next start.
- R8: A start condition, including a repeated start, restarts the transfer. A following write begins again at register 0, and SDA is released right after the start.
- R9: The target only begins pulling SDA low while the synchronised SCL is low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired-AND bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 48 | Register bank; register i sits at bits 8*i+7 down to 8*i |

## Verification
The bench builds the block with its default parameters: six registers, target address 69h and a two-stage synchroniser. Six registers keep the pointer small enough that a single write can run past the end of the bank. A single read can also cover the whole bank including the count byte. The bus quarter-period is ten system clocks, well above the four-cycle synchroniser and edge-detect delay. This makes the cycle in which SDA changes after an SCL fall deterministic, and it leaves enough cycles to run full write/readback passes for several data patterns.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } i2c_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned          NUM_REGS  = 6,
  parameter int unsigned          IDX_W     = 3,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      widx_i,
  input  logic [7:0]            wdata_i,
  input  logic [IDX_W-1:0]      ridx_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[8*g +: 8] <= RESET_VAL[8*g +: 8];
      end else if (we_i && widx_i == IDX_W'(g)) begin
        regs_o[8*g +: 8] <= wdata_i;
      end
    end
  end

  // out-of-range index reads as an idle bus
  always_comb begin
    rdata_o = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ridx_i == IDX_W'(i)) rdata_o = regs_o[8*i +: 8];
    end
  end
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned           NUM_REGS  = 6,
  parameter logic [6:0]            DEV_ADDR  = 7'h69,
  parameter int unsigned           SYNC_STG  = 2,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = 48'hFF_EB_FF_FF_1F_00
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int unsigned PTR_W    = $clog2(NUM_REGS + 1);
  localparam logic [7:0]  CNT_BYTE = 8'(NUM_REGS);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS);

  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;
  logic start_evt, stop_evt, in_wait;

  i2c_line_sync #(.STAGES(SYNC_STG)) u_scl_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .line_i(scl_i),
    .lvl_o (scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
  );
  i2c_line_sync #(.STAGES(SYNC_STG)) u_sda_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .line_i(sda_i),
    .lvl_o (sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_evt = sda_fall & scl_s;
  assign stop_evt  = sda_rise & scl_s;

  i2c_st_e          state;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [1:0]       hdr;   // 0 addr, 1 cmd, 2 count, 3 data
  logic             rd_mode;
  logic [PTR_W-1:0] ptr;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;

  assign in_wait = (state == ST_WAIT);

  cfg_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (PTR_W),
    .RESET_VAL(RESET_VAL)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .widx_i (wr_idx),
    .wdata_i(wr_data),
    .ridx_i (ptr),
    .rdata_o(rd_data),
    .regs_o (regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      hdr      <= '0;
      rd_mode  <= 1'b0;
      ptr      <= '0;
      sda_oe_o <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state    <= ST_RX;
        bit_cnt  <= '0;
        hdr      <= '0;
        rd_mode  <= 1'b0;
        ptr      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_evt) begin
        state    <= ST_IDLE;
        ptr      <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (hdr == 2'd0) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rd_mode  <= shreg[0];
                  hdr      <= 2'd1;
                  sda_oe_o <= 1'b1;
                  state    <= ST_RX_ACK;
                end else begin
                  state <= ST_WAIT;
                end
              end else begin
                sda_oe_o <= 1'b1;
                state    <= ST_RX_ACK;
                if (hdr != 2'd3) begin
                  hdr <= hdr + 2'd1;
                end else if (ptr < LAST) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr + 1'b1;
                end
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_mode) begin
                shreg    <= CNT_BYTE;
                sda_oe_o <= ~CNT_BYTE[7];
                state    <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
                state    <= ST_TX_ACK;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_oe_o <= ~shreg[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise && sda_s) begin
              state <= ST_WAIT;
            end else if (scl_fall) begin
              shreg    <= rd_data;
              sda_oe_o <= ~rd_data[7];
              state    <= ST_TX;
              if (ptr < LAST) ptr <= ptr + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk #(
  parameter int unsigned NUM_REGS = 6
) (
  input logic                                 clk_i,
  input logic                                 rst_ni,
  input logic                                 scl_s,
  input logic                                 sda_oe_o,
  input logic [NUM_REGS*8-1:0]                regs_o,
  input logic                                 wr_en,
  input logic [$clog2(NUM_REGS+1)-1:0]        wr_idx,
  input logic                                 in_wait,
  input logic                                 start_evt
);
  // R9
  pull_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  // R4
  bank_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(regs_o));

  // R5
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (int'(wr_idx) < NUM_REGS));

  // R7
  wait_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_wait |-> !sda_oe_o);

  // R8
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !sda_oe_o);
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .sda_oe_o (sda_oe_o),
  .regs_o   (regs_o),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .in_wait  (in_wait),
  .start_evt(start_evt)
);

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
  localparam int Q = 10;
  localparam logic [47:0] DEF = 48'hFF_EB_FF_FF_1F_00;
  localparam int NV = 6;
  localparam int VN[NV] = '{6, 3, 1, 6, 0, 4};
  localparam logic [47:0] VD[NV] = '{
    48'h66_55_44_33_22_11, 48'h00_00_00_C3_3C_A5, 48'h00_00_00_00_00_7E,
    48'h01_02_04_08_10_80, 48'h12_34_56_78_9A_BC, 48'h00_00_F0_0F_FF_00};
  localparam logic [7:0] VCMD[NV] = '{8'h00, 8'hFF, 8'h5A, 8'h03, 8'hEE, 8'h81};
  localparam logic [7:0] VCNT[NV] = '{8'h06, 8'h01, 8'hFF, 8'h00, 8'h09, 8'h42};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [47:0] regs;
  logic sda_bus;
  logic [47:0] model;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  cfg_i2c_target i_cfg_i2c_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic read_all(input string tag);
    logic a;
    logic [7:0] b;
    bus_start();
    wr_byte(8'hD3, a); check({tag, " R2 read addr ack"}, 48'(a), 48'd1);
    rd_byte(1'b1, b); check({tag, " R6 count"}, 48'(b), 48'd6);
    for (int r = 0; r < 6; r++) begin
      rd_byte(r != 5, b);
      check($sformatf("%s R6 reg%0d", tag, r), 48'(b), 48'(model[8*r +: 8]));
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    model = DEF;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 regs after reset", regs, DEF);
    check("R1 sda released", 48'(sda_oe), 48'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    read_all("R1");

    // vector walk: block write then readback
    for (int k = 0; k < NV; k++) begin
      bus_start();
      wr_byte(8'hD2, a); check("R2 write addr ack", 48'(a), 48'd1);
      wr_byte(VCMD[k], a); check("R3 cmd ack", 48'(a), 48'd1);
      wr_byte(VCNT[k], a); check("R3 count ack", 48'(a), 48'd1);
      for (int i = 0; i < VN[k]; i++) begin
        wr_byte(VD[k][8*i +: 8], a); check("R4 data ack", 48'(a), 48'd1);
        model[8*i +: 8] = VD[k][8*i +: 8];
      end
      bus_stop();
      check($sformatf("R4 regs after vector %0d", k), regs, model);
      read_all("R4");
    end

    // R2 foreign address: no ack, nothing stored, bus stays released
    bus_start();
    wr_byte(8'hA4, a); check("R2 foreign addr nack", 48'(a), 48'd0);
    wr_byte(8'h00, a); check("R2 foreign byte nack", 48'(a), 48'd0);
    wr_byte(8'h00, a);
    wr_byte(8'h00, a); check("R2 foreign data nack", 48'(a), 48'd0);
    bus_stop();
    check("R2 regs unchanged", regs, model);

    // R5 overrun past last register
    bus_start();
    wr_byte(8'hD2, a); wr_byte(8'h00, a); wr_byte(8'h08, a);
    for (int i = 0; i < 8; i++) begin
      wr_byte(8'hC0 + 8'(i), a);
      if (i < 6) model[8*i +: 8] = 8'hC0 + 8'(i);
      else check("R5 extra byte ack", 48'(a), 48'd1);
    end
    bus_stop();
    check("R5 regs after overrun", regs, model);

    // R8 repeated start restarts at register 0
    bus_start();
    wr_byte(8'hD2, a); wr_byte(8'h00, a); wr_byte(8'h02, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a);
    model[7:0] = 8'h11; model[15:8] = 8'h22;
    bus_start();
    wr_byte(8'hD2, a); check("R8 addr ack after restart", 48'(a), 48'd1);
    wr_byte(8'h00, a); wr_byte(8'h01, a);
    wr_byte(8'h99, a); model[7:0] = 8'h99;
    bus_stop();
    check("R8 reg0 rewritten", 48'(regs[7:0]), 48'h99);
    check("R8 regs after restart", regs, model);

    // R7 host nack ends read; later clocks read an idle bus
    bus_start();
    wr_byte(8'hD3, a);
    rd_byte(1'b0, b); check("R7 count before nack", 48'(b), 48'd6);
    rd_byte(1'b0, b); check("R7 released after nack", 48'(b), 48'hFF);
    check("R7 sda_oe low", 48'(sda_oe), 48'd0);
    bus_stop();
    read_all("R8");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule